// File: doc/BRIEF.md
# Dual-Port Channel Mailbox with Handshake Interrupts

This block is a byte-wide shared memory that a host and an I/O processor use to exchange fixed-size messages. There are seven channels. Each channel has two message slots, one carrying traffic from the host (outgoing) and one carrying traffic from the processor (incoming). Each slot is a 32-byte buffer plus its own state byte. A reply is written back into the same buffer that carried the request.

The state byte walks through four values: idle, new, received and complete. On an outgoing slot the host fills the buffer and marks it new. The processor marks it received, writes its reply and marks it complete. The host then reads the reply and returns the slot to idle. An incoming slot runs the same sequence with the two sides swapped.

The block does not interpret messages. It only watches the state bytes. When an outgoing slot enters complete it raises a sticky flag for the host. When an incoming slot enters new it raises a second sticky flag. Both flags feed one host interrupt line. A separate doorbell lets the host wake the processor.

Top module: `mbox_mailbox`

## Requirements
- R1: After reset, both interrupt flags, the host interrupt line and the doorbell are 0, and every state byte reads as idle (0).
- R2: A byte written through either port to a mapped buffer address can be read back through both ports. Read data is registered: it shows the content at the address presented one cycle earlier.
- R3: Address map for channel c (0..6) and byte b (0..31): the outgoing buffer is at c*32+b, the incoming buffer at 0x100+c*32+b, the outgoing state at 0x200+c and the incoming state at 0x208+c. Every other address (channel 7 regions, 0x207, 0x20F, 0x210 and up) reads 0, stores nothing and sets no flag.
- R4: The state encodings are idle=0, new=1, received=2, complete=3. The first flag (int0Flag) is set in the cycle after a write of 3 to an outgoing state byte whose stored value was not 3. Rewriting 3 over 3 does not set it.
- R5: The second flag (int1Flag) is set in the cycle after a write of 1 to an incoming state byte whose stored value was not 1.
- R6: Any other value written to a state byte, including values 4..255, complete on an incoming slot and new on an outgoing slot, is stored and read back but sets no flag.
- R7: A flag stays set until a one-cycle host clear pulse for that flag. If a clear and a set condition fall in the same cycle, the flag stays set.
- R8: hostIrq is high whenever at least one of the two flags is set.
- R9: If both ports write the same mapped byte in one cycle, the processor's value is stored, and the host's write has no effect on the flags.
- R10: A host ring pulse sets procDoorbell from the next cycle on, and a processor acknowledge pulse clears it. If ring and acknowledge coincide, the doorbell stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 10 | Host byte address |
| hostWe | input | 1 | Host write enable |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data, one cycle latency |
| hostClrInt0 | input | 1 | Host pulse that clears int0Flag |
| hostClrInt1 | input | 1 | Host pulse that clears int1Flag |
| hostRing | input | 1 | Host pulse that rings the processor doorbell |
| int0Flag | output | 1 | Outgoing slot entered complete |
| int1Flag | output | 1 | Incoming slot entered new |
| hostIrq | output | 1 | Combined host interrupt |
| procAddr | input | 10 | Processor byte address |
| procWe | input | 1 | Processor write enable |
| procWdata | input | 8 | Processor write data |
| procRdata | output | 8 | Processor read data, one cycle latency |
| procAck | input | 1 | Processor pulse that clears the doorbell |
| procDoorbell | output | 1 | Doorbell toward the processor |

## Verification
Two kinds of same-cycle event matter. The first is a flag set meeting a host clear. The bench drives a processor write of complete to an outgoing state byte in the same cycle as the host clear pulse, and expects the flag to stay high. The doorbell gets the same test, with ring and acknowledge in one cycle. The second is a collision: both ports write the same buffer or state byte in one cycle. The bench expects the processor's value on read-back. It also expects a host write of complete that loses the collision to leave the first flag low.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 10;
  localparam int NUM_CH      = 7;
  localparam int MSG_BYTES   = 32;
  localparam int SLOT_BYTES  = NUM_CH * MSG_BYTES;
  localparam int BUF_BYTES   = 2 * SLOT_BYTES;
  localparam int NUM_ST      = 2 * NUM_CH;
  localparam int BUF_IDX_W   = $clog2(BUF_BYTES);
  localparam int ST_IDX_W    = $clog2(NUM_ST);
  localparam int IN_BUF_BASE = 'h100;
  localparam int ST_BASE     = 'h200;
  localparam int IN_ST_OFS   = 8;

  localparam logic [DATA_W-1:0] ST_IDLE = 8'd0;
  localparam logic [DATA_W-1:0] ST_NEW  = 8'd1;
  localparam logic [DATA_W-1:0] ST_RCVD = 8'd2;
  localparam logic [DATA_W-1:0] ST_DONE = 8'd3;

  typedef enum logic [1:0] {REG_NONE, REG_BUF, REG_STATE} regionT;

  typedef struct packed {
    regionT               region;
    logic [BUF_IDX_W-1:0] bufIdx;
    logic [ST_IDX_W-1:0]  stIdx;
  } decodeT;

  typedef struct packed {
    logic                 bufWe;
    logic                 stWe;
    logic [BUF_IDX_W-1:0] bufIdx;
    logic [ST_IDX_W-1:0]  stIdx;
    logic [DATA_W-1:0]    data;
  } wrPortT;

  typedef struct packed {
    wrPortT host;
    wrPortT proc;
    decodeT hostRd;
    decodeT procRd;
  } strobeT;

  function automatic decodeT decodeAddr(input logic [ADDR_W-1:0] addr);
    decodeT d;
    int unsigned ua;
    int unsigned off;
    int unsigned slot;
    int unsigned ch;
    d    = '0;
    ua   = int'(addr);
    if (ua < ST_BASE) begin
      slot = (ua >= IN_BUF_BASE) ? 1 : 0;
      off  = (slot == 1) ? ua - IN_BUF_BASE : ua;
      ch   = off / MSG_BYTES;
      if (ch < NUM_CH) begin
        d.region = REG_BUF;
        d.bufIdx = BUF_IDX_W'(slot * SLOT_BYTES + off);
      end
    end else if (ua < ST_BASE + 2 * IN_ST_OFS) begin
      off  = ua - ST_BASE;
      slot = off / IN_ST_OFS;
      ch   = off % IN_ST_OFS;
      if (ch < NUM_CH) begin
        d.region = REG_STATE;
        d.stIdx  = ST_IDX_W'(slot * NUM_CH + ch);
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             hostAddr,
  input  logic                          hostWe,
  input  logic [DATA_W-1:0]             hostWdata,
  input  logic [ADDR_W-1:0]             procAddr,
  input  logic                          procWe,
  input  logic [DATA_W-1:0]             procWdata,
  input  logic [NUM_ST-1:0][DATA_W-1:0] stateView,
  input  logic                          hostClrInt0,
  input  logic                          hostClrInt1,
  input  logic                          hostRing,
  input  logic                          procAck,
  output strobeT                        strb,
  output logic                          int0Flag,
  output logic                          int1Flag,
  output logic                          procDoorbell
);
  decodeT hostDec;
  decodeT procDec;
  logic   collide;
  logic   setInt0;
  logic   setInt1;

  function automatic logic entersDone(input wrPortT p, input logic [DATA_W-1:0] old);
    return p.stWe && (int'(p.stIdx) < NUM_CH) && (p.data == ST_DONE) && (old != ST_DONE);
  endfunction

  function automatic logic entersNew(input wrPortT p, input logic [DATA_W-1:0] old);
    return p.stWe && (int'(p.stIdx) >= NUM_CH) && (p.data == ST_NEW) && (old != ST_NEW);
  endfunction

  always_comb begin
    hostDec = decodeAddr(hostAddr);
    procDec = decodeAddr(procAddr);
    collide = hostWe && procWe && (hostAddr == procAddr) && (procDec.region != REG_NONE);

    strb.proc.bufWe  = procWe && (procDec.region == REG_BUF);
    strb.proc.stWe   = procWe && (procDec.region == REG_STATE);
    strb.proc.bufIdx = procDec.bufIdx;
    strb.proc.stIdx  = procDec.stIdx;
    strb.proc.data   = procWdata;

    strb.host.bufWe  = hostWe && !collide && (hostDec.region == REG_BUF);
    strb.host.stWe   = hostWe && !collide && (hostDec.region == REG_STATE);
    strb.host.bufIdx = hostDec.bufIdx;
    strb.host.stIdx  = hostDec.stIdx;
    strb.host.data   = hostWdata;

    strb.hostRd = hostDec;
    strb.procRd = procDec;

    setInt0 = entersDone(strb.host, stateView[strb.host.stIdx]) ||
              entersDone(strb.proc, stateView[strb.proc.stIdx]);
    setInt1 = entersNew(strb.host, stateView[strb.host.stIdx]) ||
              entersNew(strb.proc, stateView[strb.proc.stIdx]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      int0Flag     <= 1'b0;
      int1Flag     <= 1'b0;
      procDoorbell <= 1'b0;
    end else begin
      int0Flag     <= setInt0 || (int0Flag && !hostClrInt0);
      int1Flag     <= setInt1 || (int1Flag && !hostClrInt1);
      procDoorbell <= hostRing || (procDoorbell && !procAck);
    end
  end
endmodule

// File: rtl/mbox_data.sv
module mbox_data
  import mbox_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  strobeT                        strb,
  output logic [DATA_W-1:0]             hostRdata,
  output logic [DATA_W-1:0]             procRdata,
  output logic [NUM_ST-1:0][DATA_W-1:0] stateView
);
  logic [DATA_W-1:0]             bufMem [BUF_BYTES];
  logic [NUM_ST-1:0][DATA_W-1:0] stMem;
  decodeT                        rdDec [2];

  assign rdDec[0]  = strb.hostRd;
  assign rdDec[1]  = strb.procRd;
  assign stateView = stMem;

  always_ff @(posedge clk) begin
    if (strb.host.bufWe) bufMem[strb.host.bufIdx] <= strb.host.data;
    if (strb.proc.bufWe) bufMem[strb.proc.bufIdx] <= strb.proc.data;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stMem <= '0;
    end else begin
      if (strb.host.stWe) stMem[strb.host.stIdx] <= strb.host.data;
      if (strb.proc.stWe) stMem[strb.proc.stIdx] <= strb.proc.data;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : gRd
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        q <= '0;
      end else begin
        case (rdDec[g].region)
          REG_BUF:   q <= bufMem[rdDec[g].bufIdx];
          REG_STATE: q <= stMem[rdDec[g].stIdx];
          default:   q <= '0;
        endcase
      end
    end
  end

  assign hostRdata = gRd[0].q;
  assign procRdata = gRd[1].q;
endmodule

// File: rtl/mbox_mailbox.sv
module mbox_mailbox
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWe,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic              hostClrInt0,
  input  logic              hostClrInt1,
  input  logic              hostRing,
  output logic              int0Flag,
  output logic              int1Flag,
  output logic              hostIrq,
  input  logic [ADDR_W-1:0] procAddr,
  input  logic              procWe,
  input  logic [DATA_W-1:0] procWdata,
  output logic [DATA_W-1:0] procRdata,
  input  logic              procAck,
  output logic              procDoorbell
);
  strobeT                        strb;
  logic [NUM_ST-1:0][DATA_W-1:0] stateView;

  mbox_ctrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .hostAddr(hostAddr), .hostWe(hostWe), .hostWdata(hostWdata),
    .procAddr(procAddr), .procWe(procWe), .procWdata(procWdata),
    .stateView(stateView),
    .hostClrInt0(hostClrInt0), .hostClrInt1(hostClrInt1),
    .hostRing(hostRing), .procAck(procAck),
    .strb(strb),
    .int0Flag(int0Flag), .int1Flag(int1Flag), .procDoorbell(procDoorbell)
  );

  mbox_data i_data (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hostRdata(hostRdata), .procRdata(procRdata), .stateView(stateView)
  );

  assign hostIrq = int0Flag || int1Flag;
endmodule

// File: rtl/mbox_mailbox_chk.sv
module mbox_mailbox_chk (
  input logic       clk,
  input logic       rstN,
  input logic [9:0] hostAddr,
  input logic       hostWe,
  input logic [7:0] hostWdata,
  input logic       hostClrInt0,
  input logic       hostClrInt1,
  input logic       hostRing,
  input logic       int0Flag,
  input logic       int1Flag,
  input logic [9:0] procAddr,
  input logic       procWe,
  input logic [7:0] procWdata,
  input logic       procAck,
  input logic       procDoorbell
);
  logic hostDoneWr, procDoneWr, hostNewWr, procNewWr;
  assign hostDoneWr = hostWe && hostWdata == 8'd3 && hostAddr >= 10'h200 && hostAddr <= 10'h206;
  assign procDoneWr = procWe && procWdata == 8'd3 && procAddr >= 10'h200 && procAddr <= 10'h206;
  assign hostNewWr  = hostWe && hostWdata == 8'd1 && hostAddr >= 10'h208 && hostAddr <= 10'h20E;
  assign procNewWr  = procWe && procWdata == 8'd1 && procAddr >= 10'h208 && procAddr <= 10'h20E;

  // R4
  int0_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(int0Flag) |-> $past(hostDoneWr || procDoneWr));
  // R5
  int1_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(int1Flag) |-> $past(hostNewWr || procNewWr));
  // R7
  int0_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    int0Flag && !hostClrInt0 |=> int0Flag);
  // R7
  int1_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    int1Flag && !hostClrInt1 |=> int1Flag);
  // R7
  int0_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(int0Flag) |-> $past(hostClrInt0));
  // R10
  bell_ring_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostRing |=> procDoorbell);
  // R10
  bell_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(procDoorbell) |-> $past(procAck));
endmodule

bind mbox_mailbox mbox_mailbox_chk i_chk (
  .clk(clk), .rstN(rstN),
  .hostAddr(hostAddr), .hostWe(hostWe), .hostWdata(hostWdata),
  .hostClrInt0(hostClrInt0), .hostClrInt1(hostClrInt1), .hostRing(hostRing),
  .int0Flag(int0Flag), .int1Flag(int1Flag),
  .procAddr(procAddr), .procWe(procWe), .procWdata(procWdata),
  .procAck(procAck), .procDoorbell(procDoorbell)
);

// File: tb/test_mbox_mailbox.sv
module test_mbox_mailbox;
  logic       clk = 0;
  logic       rstN = 0;
  logic [9:0] hostAddr = 0;
  logic       hostWe = 0;
  logic [7:0] hostWdata = 0;
  logic [7:0] hostRdata;
  logic       hostClrInt0 = 0, hostClrInt1 = 0, hostRing = 0;
  logic       int0Flag, int1Flag, hostIrq;
  logic [9:0] procAddr = 0;
  logic       procWe = 0;
  logic [7:0] procWdata = 0;
  logic [7:0] procRdata;
  logic       procAck = 0;
  logic       procDoorbell;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mbox_mailbox i_mbox_mailbox (.*);

  task automatic check(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hWr(logic [9:0] a, logic [7:0] d);
    @(negedge clk); hostAddr = a; hostWdata = d; hostWe = 1;
    @(negedge clk); hostWe = 0;
  endtask

  task automatic pWr(logic [9:0] a, logic [7:0] d);
    @(negedge clk); procAddr = a; procWdata = d; procWe = 1;
    @(negedge clk); procWe = 0;
  endtask

  task automatic bothWr(logic [9:0] ha, logic [7:0] hd, logic [9:0] pa, logic [7:0] pd);
    @(negedge clk); hostAddr = ha; hostWdata = hd; hostWe = 1;
    procAddr = pa; procWdata = pd; procWe = 1;
    @(negedge clk); hostWe = 0; procWe = 0;
  endtask

  task automatic hRd(logic [9:0] a, output logic [7:0] v);
    @(negedge clk); hostAddr = a;
    @(negedge clk); v = hostRdata;
  endtask

  task automatic pRd(logic [9:0] a, output logic [7:0] v);
    @(negedge clk); procAddr = a;
    @(negedge clk); v = procRdata;
  endtask

  task automatic clrFlags(logic c0, logic c1);
    @(negedge clk); hostClrInt0 = c0; hostClrInt1 = c1;
    @(negedge clk); hostClrInt0 = 0; hostClrInt1 = 0;
  endtask

  task automatic testReset();
    logic [7:0] v;
    check("R1 int0", int0Flag, 0);
    check("R1 int1", int1Flag, 0);
    check("R1 irq", hostIrq, 0);
    check("R1 doorbell", procDoorbell, 0);
    hRd(10'h200, v); check("R1 out state", v, 0);
    pRd(10'h20B, v); check("R1 in state", v, 0);
  endtask

  task automatic testStorage();
    logic [7:0] v;
    hWr(10'h045, 8'hA5);
    pRd(10'h045, v); check("R2 host->proc", v, 8'hA5);
    hRd(10'h045, v); check("R2 host readback", v, 8'hA5);
    pWr(10'h1C3, 8'h3C);
    hRd(10'h1C3, v); check("R2 proc->host", v, 8'h3C);
  endtask

  task automatic testMap();
    logic [7:0] v;
    hWr(10'h0E0, 8'h77); hRd(10'h0E0, v); check("R3 ch7 out buffer", v, 0);
    pWr(10'h1E5, 8'h66); pRd(10'h1E5, v); check("R3 ch7 in buffer", v, 0);
    pWr(10'h207, 8'h03); hRd(10'h207, v); check("R3 gap state", v, 0);
    check("R3 gap no int0", int0Flag, 0);
    hWr(10'h20F, 8'h01); check("R3 gap no int1", int1Flag, 0);
    hWr(10'h3FF, 8'h55); hRd(10'h3FF, v); check("R3 high addr", v, 0);
    hWr(10'h0DF, 8'h12); pRd(10'h0DF, v); check("R3 last out byte ch6", v, 8'h12);
  endtask

  task automatic testOutgoing();
    logic [7:0] v;
    hWr(10'h020, 8'h41);
    hWr(10'h201, 8'h01);
    check("R6 new on outgoing no int0", int0Flag, 0);
    pRd(10'h201, v); check("R4 proc sees new", v, 1);
    pWr(10'h201, 8'h02); check("R4 received no int0", int0Flag, 0);
    pWr(10'h020, 8'h99);
    pWr(10'h201, 8'h03);
    check("R4 complete sets int0", int0Flag, 1);
    check("R8 irq from int0", hostIrq, 1);
    hRd(10'h020, v); check("R4 reply in same buffer", v, 8'h99);
    hWr(10'h201, 8'h00);
    clrFlags(1, 0);
    check("R7 int0 cleared", int0Flag, 0);
    check("R8 irq low", hostIrq, 0);
    pWr(10'h202, 8'h03); check("R4 second entry", int0Flag, 1);
    clrFlags(1, 0);
    pWr(10'h202, 8'h03); check("R4 3 over 3 no set", int0Flag, 0);
  endtask

  task automatic testIncoming();
    logic [7:0] v;
    pWr(10'h180, 8'h5A);
    pWr(10'h20C, 8'h01);
    check("R5 new sets int1", int1Flag, 1);
    check("R8 irq from int1", hostIrq, 1);
    hRd(10'h180, v); check("R5 host reads msg", v, 8'h5A);
    hWr(10'h20C, 8'h02);
    hWr(10'h180, 8'hC3);
    hWr(10'h20C, 8'h03);
    check("R6 complete on incoming no int0", int0Flag, 0);
    pRd(10'h180, v); check("R5 proc reads reply", v, 8'hC3);
    pWr(10'h20C, 8'h00);
    clrFlags(0, 1);
    check("R7 int1 cleared", int1Flag, 0);
  endtask

  task automatic testOther();
    logic [7:0] v;
    hWr(10'h203, 8'h07); hRd(10'h203, v); check("R6 odd value stored", v, 8'h07);
    check("R6 odd no int0", int0Flag, 0);
    pWr(10'h20A, 8'hFF); pRd(10'h20A, v); check("R6 0xFF stored", v, 8'hFF);
    check("R6 no int1", int1Flag, 0);
  endtask

  task automatic testSticky();
    pWr(10'h205, 8'h03);
    repeat (4) @(negedge clk);
    check("R7 int0 sticky", int0Flag, 1);
    @(negedge clk); procAddr = 10'h206; procWdata = 8'h03; procWe = 1; hostClrInt0 = 1;
    @(negedge clk); procWe = 0; hostClrInt0 = 0;
    check("R7 set beats clear", int0Flag, 1);
    clrFlags(1, 1);
    check("R7 clear alone", int0Flag, 0);
    check("R7 int1 clear while low", int1Flag, 0);
  endtask

  task automatic testCollision();
    logic [7:0] v;
    bothWr(10'h204, 8'h11, 10'h204, 8'h22);
    hRd(10'h204, v); check("R9 state collision proc wins", v, 8'h22);
    bothWr(10'h0C0, 8'hAA, 10'h0C0, 8'hBB);
    pRd(10'h0C0, v); check("R9 buffer collision proc wins", v, 8'hBB);
    bothWr(10'h204, 8'h03, 10'h204, 8'h02);
    check("R9 losing host write no int0", int0Flag, 0);
    hRd(10'h204, v); check("R9 stored proc value", v, 8'h02);
  endtask

  task automatic testDoorbell();
    @(negedge clk); hostRing = 1; @(negedge clk); hostRing = 0;
    check("R10 ring sets", procDoorbell, 1);
    repeat (3) @(negedge clk);
    check("R10 doorbell holds", procDoorbell, 1);
    @(negedge clk); hostRing = 1; procAck = 1; @(negedge clk); hostRing = 0; procAck = 0;
    check("R10 ring beats ack", procDoorbell, 1);
    @(negedge clk); procAck = 1; @(negedge clk); procAck = 0;
    check("R10 ack clears", procDoorbell, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testStorage();
    testMap();
    testOutgoing();
    testIncoming();
    testOther();
    testSticky();
    testCollision();
    testDoorbell();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule